// File: doc/BRIEF.md
# Serial Command Decoder with Auto-Increment

This block sits behind a three-wire synchronous serial link made of an active-low select, a shift clock and a data line. It puts the incoming bits together into bytes, the least significant bit first. It decodes each byte as a command for a dot-matrix display controller, or as data for the command that came before it. The results leave the block as one-cycle write strobes, each with its own address and data lines. They go to three RAMs held outside the block, and to four small control registers.

Single-byte commands set the port levels, the digit count and the all-lights mode. The duty command takes two bytes. Each RAM command opens a stream that continues until select goes high, and every data byte in it moves a write address forward:

- The character-code RAM and the symbol RAM have a 5-bit address with 24 locations of storage. Bytes aimed at the eight addresses above the last location are dropped, but they still move the address forward.
- The 35-bit pattern RAM collects five column bytes into a single write.

The serial inputs are taken to be already synchronous to the block clock, and each is much slower than that clock.

Top module: `serial_cmd_decoder`

## Requirements
- R1: Data is shifted in only on a rising edge of `ser_clk` while `ser_csn` is low. Rising edges of `ser_clk` while `ser_csn` is high produce no strobe.
- R2: Bytes are counted in groups of eight bits from the falling edge of `ser_csn`. Every complete byte that calls for a write raises exactly one strobe for one clock cycle. No strobe is ever high in two consecutive cycles.
- R3: The command opcode is byte bits 7..5, as the value {b7,b6,b5}: 001 selects the character-code write, 010 the pattern write, 011 the symbol write, 100 the port set, 101 the duty set, 110 the digit-count set and 111 the all-lights set.
- R4: A character-code command loads its address from bits 4..0. Each following byte in the same select frame is written to the current address, and the address then increments.
- R5: For the character-code and symbol streams, bytes at addresses 24 to 31 produce no write, but the address still increments. The address wraps from 31 to 0. No strobe ever carries an address of 24 or above.
- R6: A pattern command loads a 4-bit address from bits 3..0, and bit 4 is ignored. The next five bytes are columns k = 0..4, and bits 6..0 of column k become pattern bits k, k+5, ..., k+30; bit 7 is ignored. The fifth byte raises a single write, then the address increments, wrapping from 15 to 0.
- R7: The duty command takes duty bits 1..0 from its own bits 1..0 and duty bits 9..2 from the next byte. After that second byte, the next byte is decoded as a command.
- R8: Symbol data is bits 3..0 of each data byte. The port levels are bits 3..0 of the port command. The digit code is bits 3..0 of the digit command. The all-lights mode is bits 1..0 of the all-lights command: bit 0 requests all off and bit 1 requests all on.
- R9: A rising edge of `ser_csn` throws away a partial byte and a partial pattern. After that edge, the first byte is decoded as a command.
- R10: Opcode 000 produces no strobe and changes no state, so the next byte is still decoded as a command.
- R11: After reset, every strobe is low and every address and data output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_csn | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data, least significant bit first |
| code_we | output | 1 | Character-code RAM write strobe |
| code_addr | output | 5 | Character-code RAM address |
| code_data | output | 8 | Character code |
| pat_we | output | 1 | Pattern RAM write strobe |
| pat_addr | output | 4 | Pattern RAM address |
| pat_data | output | 35 | Assembled 35-bit pattern |
| sym_we | output | 1 | Symbol RAM write strobe |
| sym_addr | output | 5 | Symbol RAM address |
| sym_data | output | 4 | Symbol bits |
| port_we | output | 1 | Port register strobe |
| port_val | output | 4 | Port levels |
| digit_we | output | 1 | Digit-count register strobe |
| digit_code | output | 4 | Digit-count code |
| lights_we | output | 1 | All-lights register strobe |
| lights_mode | output | 2 | All-lights mode |
| duty_we | output | 1 | Duty register strobe |
| duty_val | output | 10 | Duty value |

## Verification
The character-code stream starts two addresses below the end of storage. It therefore passes through the eight dropped slots and the wrap to address 0 in one frame, which shows whether those slots are skipped correctly and whether the address keeps counting through them. Two pattern writes back to back at address 15 use columns with bit 7 set and different values in every row. This separates a wrong column-to-bit mapping from a failed wrap to address 0. Frames that mix commands test the points where the decoder must go back to reading commands: right after the duty byte, after a reserved opcode, and after a select edge that cuts off a partial byte or a partial pattern. Shift-clock pulses sent while select is high must produce no strobe.

// File: rtl/serial_cmd_decoder.sv
module serial_cmd_decoder #(
  parameter int CODE_AW    = 5,
  parameter int CODE_DEPTH = 24,
  parameter int PAT_AW     = 4,
  parameter int COLS       = 5,
  parameter int ROWS       = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_csn,
  input  logic                 ser_clk,
  input  logic                 ser_dat,
  output logic                 code_we,
  output logic [CODE_AW-1:0]   code_addr,
  output logic [7:0]           code_data,
  output logic                 pat_we,
  output logic [PAT_AW-1:0]    pat_addr,
  output logic [COLS*ROWS-1:0] pat_data,
  output logic                 sym_we,
  output logic [CODE_AW-1:0]   sym_addr,
  output logic [3:0]           sym_data,
  output logic                 port_we,
  output logic [3:0]           port_val,
  output logic                 digit_we,
  output logic [3:0]           digit_code,
  output logic                 lights_we,
  output logic [1:0]           lights_mode,
  output logic                 duty_we,
  output logic [9:0]           duty_val
);
  localparam int PW    = COLS * ROWS;
  localparam int COL_W = $clog2(COLS);
  localparam logic [CODE_AW-1:0] CODE_LIM = CODE_AW'(CODE_DEPTH);
  localparam logic [COL_W-1:0]   COL_LAST = COL_W'(COLS - 1);

  typedef enum logic [2:0] {S_CMD, S_CODE, S_PAT, S_SYM, S_DUTY} st_t;

  st_t                     st;
  logic                    sclk_q, csn_q;
  logic [7:0]              shreg;
  logic [2:0]              bitcnt;
  logic [CODE_AW-1:0]      code_ptr, sym_ptr;
  logic [PAT_AW-1:0]       pat_ptr;
  logic [COL_W-1:0]        col;
  logic [ROWS*(COLS-1)-1:0] acc;
  logic [1:0]              duty_lo;
  logic [PW-1:0]           pat_next;

  wire       sclk_rise = ser_clk & ~sclk_q;
  wire       cs_edge   = ser_csn ^ csn_q;
  wire [7:0] byte_w    = {ser_dat, shreg[7:1]};
  wire       byte_done = sclk_rise & ~ser_csn & ~cs_edge & (bitcnt == 3'd7);
  wire [ROWS*COLS-1:0] cols = {byte_w[ROWS-1:0], acc};

  always_comb begin
    for (int k = 0; k < COLS; k++)
      for (int j = 0; j < ROWS; j++)
        pat_next[k + COLS*j] = cols[k*ROWS + j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
      shreg  <= '0;
      bitcnt <= '0;
    end else begin
      sclk_q <= ser_clk;
      csn_q  <= ser_csn;
      if (cs_edge) bitcnt <= '0;
      else if (sclk_rise && !ser_csn) begin
        shreg  <= byte_w;
        bitcnt <= bitcnt + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_CMD; code_ptr <= '0; sym_ptr <= '0; pat_ptr <= '0;
      col <= '0; acc <= '0; duty_lo <= '0;
      code_we <= 1'b0; code_addr <= '0; code_data <= '0;
      pat_we <= 1'b0; pat_addr <= '0; pat_data <= '0;
      sym_we <= 1'b0; sym_addr <= '0; sym_data <= '0;
      port_we <= 1'b0; port_val <= '0;
      digit_we <= 1'b0; digit_code <= '0;
      lights_we <= 1'b0; lights_mode <= '0;
      duty_we <= 1'b0; duty_val <= '0;
    end else begin
      code_we <= 1'b0; pat_we <= 1'b0; sym_we <= 1'b0; port_we <= 1'b0;
      digit_we <= 1'b0; lights_we <= 1'b0; duty_we <= 1'b0;
      if (ser_csn && !csn_q) begin
        st  <= S_CMD;
        col <= '0;
      end else if (byte_done) begin
        unique case (st)
          S_CMD: begin
            unique case (byte_w[7:5])
              3'b001: begin code_ptr <= byte_w[CODE_AW-1:0]; st <= S_CODE; end
              3'b010: begin pat_ptr <= byte_w[PAT_AW-1:0]; col <= '0; st <= S_PAT; end
              3'b011: begin sym_ptr <= byte_w[CODE_AW-1:0]; st <= S_SYM; end
              3'b100: begin port_we <= 1'b1; port_val <= byte_w[3:0]; end
              3'b101: begin duty_lo <= byte_w[1:0]; st <= S_DUTY; end
              3'b110: begin digit_we <= 1'b1; digit_code <= byte_w[3:0]; end
              3'b111: begin lights_we <= 1'b1; lights_mode <= byte_w[1:0]; end
              default: ;
            endcase
          end
          S_CODE: begin
            if (code_ptr < CODE_LIM) begin
              code_we <= 1'b1; code_addr <= code_ptr; code_data <= byte_w;
            end
            code_ptr <= code_ptr + CODE_AW'(1);
          end
          S_SYM: begin
            if (sym_ptr < CODE_LIM) begin
              sym_we <= 1'b1; sym_addr <= sym_ptr; sym_data <= byte_w[3:0];
            end
            sym_ptr <= sym_ptr + CODE_AW'(1);
          end
          S_PAT: begin
            if (col == COL_LAST) begin
              pat_we <= 1'b1; pat_addr <= pat_ptr; pat_data <= pat_next;
              pat_ptr <= pat_ptr + PAT_AW'(1);
              col <= '0;
            end else begin
              acc[col*ROWS +: ROWS] <= byte_w[ROWS-1:0];
              col <= col + COL_W'(1);
            end
          end
          S_DUTY: begin
            duty_we <= 1'b1; duty_val <= {byte_w, duty_lo}; st <= S_CMD;
          end
          default: st <= S_CMD;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_cmd_decoder_chk.sv
module serial_cmd_decoder_chk #(
  parameter int CODE_AW    = 5,
  parameter int CODE_DEPTH = 24,
  parameter int PAT_AW     = 4,
  parameter int COLS       = 5,
  parameter int ROWS       = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ser_csn,
  input logic                 ser_clk,
  input logic                 ser_dat,
  input logic                 code_we,
  input logic [CODE_AW-1:0]   code_addr,
  input logic [7:0]           code_data,
  input logic                 pat_we,
  input logic [PAT_AW-1:0]    pat_addr,
  input logic [COLS*ROWS-1:0] pat_data,
  input logic                 sym_we,
  input logic [CODE_AW-1:0]   sym_addr,
  input logic [3:0]           sym_data,
  input logic                 port_we,
  input logic [3:0]           port_val,
  input logic                 digit_we,
  input logic [3:0]           digit_code,
  input logic                 lights_we,
  input logic [1:0]           lights_mode,
  input logic                 duty_we,
  input logic [9:0]           duty_val
);
  localparam logic [CODE_AW-1:0] LIM = CODE_AW'(CODE_DEPTH);
  wire [6:0] we_all = {code_we, pat_we, sym_we, port_we, digit_we, lights_we, duty_we};

  AST_ONE_STROBE:   assert property (@(posedge clk) disable iff (!rst_n) $onehot0(we_all)); // R2
  AST_NO_REPEAT:    assert property (@(posedge clk) disable iff (!rst_n) (we_all != 7'd0) |=> (we_all == 7'd0)); // R2
  AST_CSN_HIGH:     assert property (@(posedge clk) disable iff (!rst_n) $past(ser_csn) |-> (we_all == 7'd0)); // R1
  AST_CODE_RANGE:   assert property (@(posedge clk) disable iff (!rst_n) code_we |-> (code_addr < LIM)); // R5
  AST_SYM_RANGE:    assert property (@(posedge clk) disable iff (!rst_n) sym_we |-> (sym_addr < LIM)); // R5
  AST_DATA_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) !code_we |-> $stable(code_data) || $past(!rst_n)); // R4
endmodule

bind serial_cmd_decoder serial_cmd_decoder_chk chk_i (.*);

// File: tb/serial_cmd_decoder_tb.sv
module serial_cmd_decoder_tb_top;
  logic clk = 0, rst_n = 0, ser_csn = 1, ser_clk = 0, ser_dat = 0;
  logic code_we, pat_we, sym_we, port_we, digit_we, lights_we, duty_we;
  logic [4:0] code_addr, sym_addr;
  logic [7:0] code_data;
  logic [3:0] pat_addr, sym_data, port_val, digit_code;
  logic [34:0] pat_data;
  logic [1:0] lights_mode;
  logic [9:0] duty_val;

  always #10 clk = ~clk;

  serial_cmd_decoder dut_i (.*);

  int n_chk = 0, n_fail = 0;
  int n_code, n_sym, n_pat, n_port, n_digit, n_lights, n_duty, n_dbl;
  logic [4:0] code_a [0:15];
  logic [7:0] code_d [0:15];
  logic [4:0] sym_a [0:15];
  logic [3:0] sym_d [0:15];
  logic [3:0] pat_a [0:3];
  logic [34:0] pat_d [0:3];
  logic [3:0] l_port, l_digit;
  logic [1:0] l_lights;
  logic [9:0] l_duty;
  logic prev_any = 0;

  always @(negedge clk) begin
    if (code_we) begin code_a[n_code & 15] = code_addr; code_d[n_code & 15] = code_data; n_code++; end
    if (sym_we)  begin sym_a[n_sym & 15] = sym_addr; sym_d[n_sym & 15] = sym_data; n_sym++; end
    if (pat_we)  begin pat_a[n_pat & 3] = pat_addr; pat_d[n_pat & 3] = pat_data; n_pat++; end
    if (port_we)   begin l_port = port_val; n_port++; end
    if (digit_we)  begin l_digit = digit_code; n_digit++; end
    if (lights_we) begin l_lights = lights_mode; n_lights++; end
    if (duty_we)   begin l_duty = duty_val; n_duty++; end
    if (prev_any && (code_we | pat_we | sym_we | port_we | digit_we | lights_we | duty_we)) n_dbl++;
    prev_any = code_we | pat_we | sym_we | port_we | digit_we | lights_we | duty_we;
  end

  task automatic clr();
    n_code = 0; n_sym = 0; n_pat = 0; n_port = 0; n_digit = 0; n_lights = 0; n_duty = 0;
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    ser_dat = b; tick(2); ser_clk = 1; tick(2); ser_clk = 0;
  endtask

  task automatic send(input logic [7:0] b);
    for (int i = 0; i < 8; i++) bit_out(b[i]);
  endtask

  task automatic cs_lo(); tick(2); ser_csn = 0; tick(2); endtask
  task automatic cs_hi(); tick(3); ser_csn = 1; tick(4); endtask

  function automatic logic [34:0] pat_of(input logic [39:0] c);
    logic [34:0] r;
    for (int k = 0; k < 5; k++)
      for (int j = 0; j < 7; j++) r[k + 5*j] = c[k*8 + j];
    return r;
  endfunction

  initial begin
    #4ms;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [39:0] c1, c2;
    logic [4:0] ea;
    int wi;
    clr(); n_dbl = 0;
    tick(3);
    // R11 reset state
    chk({code_we, pat_we, sym_we, port_we, digit_we, lights_we, duty_we} == 0 &&
        code_addr == 0 && code_data == 0 && pat_data == 0 && duty_val == 0 && port_val == 0,
        "R11 reset outputs", {code_addr, code_data}, 0);
    rst_n = 1; tick(3);

    // R4 R5 code stream across dropped slots and wrap
    cs_lo(); send(8'h20 | 8'd22);
    for (int i = 0; i < 12; i++) send(8'h40 + 8'(i));
    cs_hi();
    chk(n_code == 4, "R5 code write count", n_code, 4);
    wi = 0;
    for (int i = 0; i < 12; i++) begin
      ea = 5'(22 + i);
      if (ea < 24 && wi < 4) begin
        chk(code_a[wi] == ea && code_d[wi] == 8'h40 + 8'(i), "R4 code addr/data",
            {code_a[wi], code_d[wi]}, {ea, 8'h40 + 8'(i)});
        wi++;
      end
    end

    // R8 R5 symbol stream
    clr(); cs_lo(); send(8'h63); send(8'hF5); send(8'hA2); cs_hi();
    chk(n_sym == 2 && sym_a[0] == 3 && sym_d[0] == 5, "R8 symbol first", {sym_a[0], sym_d[0]}, {5'd3, 4'd5});
    chk(sym_a[1] == 4 && sym_d[1] == 2, "R8 symbol second", {sym_a[1], sym_d[1]}, {5'd4, 4'd2});

    // R6 pattern write at 15, then wrap to 0
    clr();
    c1 = {8'h81, 8'h7F, 8'hD5, 8'h2A, 8'h85};
    c2 = {8'h40, 8'h33, 8'h0C, 8'hFF, 8'h11};
    cs_lo(); send(8'h5F);
    for (int k = 0; k < 5; k++) send(c1[k*8 +: 8]);
    for (int k = 0; k < 5; k++) send(c2[k*8 +: 8]);
    cs_hi();
    chk(n_pat == 2, "R6 pattern write count", n_pat, 2);
    chk(pat_a[0] == 15 && pat_d[0] == pat_of(c1), "R6 pattern at 15", {pat_a[0], pat_d[0]}, {4'd15, pat_of(c1)});
    chk(pat_a[1] == 0 && pat_d[1] == pat_of(c2), "R6 pattern wrap to 0", {pat_a[1], pat_d[1]}, {4'd0, pat_of(c2)});

    // R3 R8 single-byte commands in one frame
    clr(); cs_lo(); send(8'h8A); send(8'hC7); send(8'hE2); cs_hi();
    chk(n_port == 1 && l_port == 4'hA, "R3 port set", l_port, 4'hA);
    chk(n_digit == 1 && l_digit == 4'h7, "R8 digit code", l_digit, 4'h7);
    chk(n_lights == 1 && l_lights == 2'd2, "R8 lights mode", l_lights, 2'd2);

    // R7 duty then back to command
    clr(); cs_lo(); send(8'hA3); send(8'hF0); send(8'h85); cs_hi();
    chk(n_duty == 1 && l_duty == 10'h3C3, "R7 duty value", l_duty, 10'h3C3);
    chk(n_port == 1 && l_port == 4'h5, "R7 command after duty", l_port, 4'h5);

    // R10 reserved opcode ignored
    clr(); cs_lo(); send(8'h1F); send(8'h83); cs_hi();
    chk(n_code + n_sym + n_pat + n_digit + n_lights + n_duty == 0, "R10 no strobe", n_code + n_sym, 0);
    chk(n_port == 1 && l_port == 4'h3, "R10 next byte is command", l_port, 4'h3);

    // R9 abort of partial byte
    clr(); cs_lo(); for (int i = 0; i < 4; i++) bit_out(1'b1); cs_hi();
    cs_lo(); send(8'h89); cs_hi();
    chk(n_port == 1 && l_port == 4'h9, "R9 partial byte dropped", l_port, 4'h9);

    // R9 abort of partial pattern
    clr(); cs_lo(); send(8'h42); send(8'h7F); send(8'h7F); cs_hi();
    cs_lo(); send(8'h42);
    for (int k = 0; k < 5; k++) send(c2[k*8 +: 8]);
    cs_hi();
    chk(n_pat == 1 && pat_a[0] == 2 && pat_d[0] == pat_of(c2), "R9 partial pattern dropped",
        {pat_a[0], pat_d[0]}, {4'd2, pat_of(c2)});

    // R1 clocks with select high
    clr();
    for (int i = 0; i < 24; i++) bit_out(1'b1);
    tick(4);
    chk(n_code + n_sym + n_pat + n_port + n_digit + n_lights + n_duty == 0, "R1 idle clocks",
        n_port + n_lights, 0);

    // R2 strobes one cycle wide
    chk(n_dbl == 0, "R2 strobe width", n_dbl, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule